// File: doc/BRIEF.md
# Accumulator Processor with Interrupt Check

A small stored-program processor built around a single accumulator. Code and data share one single-port memory of 16-bit words. A program counter, an opcode register, a memory address register and a memory buffer register form the datapath. Each instruction word holds a 4-bit opcode in its top nibble and a 12-bit direct operand address below it. The block executes load, store and a sign-magnitude add against memory. Every other opcode except return-from-interrupt behaves as a no-op.

After each instruction's execute phase the core spends one cycle in an interrupt check. If the level-sensitive request is high and interrupts are enabled, the core copies the program counter and the accumulator into shadow registers, clears the enable and continues at a fixed handler address. A return-from-interrupt opcode restores both values and sets the enable again. Memory accesses use a request/acknowledge handshake, so the memory may take any number of cycles.

Top module: `acc_cpu`

## Requirements
- R1: While rst_ni is low no memory request is made. After reset the first request is a read (mem_we_o low) at address 0, the accumulator is 0 and interrupts are disabled.
- R2: Instruction fields: bits [15:12] are the opcode and bits [11:0] are the operand address. Instructions are fetched from consecutive addresses, and the program counter steps by one (modulo 4096) after each fetch.
- R3: Opcode 4'h1 reads the word at the operand address into the accumulator unchanged, including the pattern 16'h8000.
- R4: Opcode 4'h2 writes the accumulator to the operand address.
- R5: Opcode 4'h5 adds the memory word to the accumulator in sign-magnitude form (bit 15 is the sign, 1 means negative; bits 14:0 are the magnitude). If both signs are equal, the magnitudes add modulo 2^15 and the sign is kept.
- R6: If the signs differ, the smaller magnitude is subtracted from the larger and the result takes the sign of the larger. Any add whose result magnitude is zero gives 16'h0000.
- R7: Opcodes 0, 3, 4 and 6 to 14 change neither memory nor the accumulator.
- R8: A request keeps mem_req_o, mem_addr_o, mem_we_o and mem_wdata_o stable until the cycle in which mem_ack_i is high. Read data is taken from mem_rdata_i in that cycle.
- R9: After each instruction, if irq_i is high and interrupts are enabled, the core saves the address of the next instruction and the accumulator, disables interrupts, and fetches next from 12'hF00.
- R10: While interrupts are disabled, irq_i is ignored. A request still held high is taken at the first check after the return from the handler.
- R11: Opcode 4'hF restores the saved program counter and accumulator and enables interrupts. After reset the saved values are address 1 and accumulator 0, so this opcode placed at address 0 arms interrupts and continues at address 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_i | input | 1 | Level-sensitive interrupt request |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Access is a write |
| mem_addr_o | output | 12 | Word address, from the address register |
| mem_wdata_o | output | 16 | Write data, from the buffer register |
| mem_rdata_i | input | 16 | Read data, valid with acknowledge |
| mem_ack_i | input | 1 | Access completes this cycle |

## Verification
The bench builds the core with its default values: a 12-bit address (16-bit words), handler address 12'hF00 and reset address 0. With these values the full 4096-word memory can be modelled directly. Code, the data window at 12'h800 and the handler at 12'hF00 then occupy separate regions, so every memory access can be classified from the ports alone. Random programs mixing loads, stores, adds and undefined opcodes are run under random acknowledge latency, and the resulting data window is compared with an instruction-level model. Directed programs cover the add corner cases and the masking, retaking and return behaviour of the interrupt.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;
  localparam int OP_W = 4;

  localparam logic [OP_W-1:0] OP_LOAD  = 4'h1;
  localparam logic [OP_W-1:0] OP_STORE = 4'h2;
  localparam logic [OP_W-1:0] OP_ADD   = 4'h5;
  localparam logic [OP_W-1:0] OP_RETI  = 4'hF;

  typedef enum logic [2:0] {
    S_FADR,  // program counter to address register
    S_FRD,   // instruction read
    S_DEC,   // latch opcode, step pc, load operand address
    S_EXE,   // operand access or register move
    S_WB,    // accumulator update
    S_IRQ    // interrupt check
  } state_e;
endpackage

// File: rtl/acc_cpu_alu.sv
module acc_cpu_alu #(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic [DATA_W-1:0] sum_o
);
  localparam int MAG_W = DATA_W - 1;

  logic             sa, sb, sr;
  logic [MAG_W-1:0] ma, mb, mr;

  assign sa = a_i[DATA_W-1];
  assign sb = b_i[DATA_W-1];
  assign ma = a_i[MAG_W-1:0];
  assign mb = b_i[MAG_W-1:0];

  always_comb begin
    if (sa == sb) begin
      mr = ma + mb;
      sr = sa;
    end else if (ma >= mb) begin
      mr = ma - mb;
      sr = sa;
    end else begin
      mr = mb - ma;
      sr = sb;
    end
    if (mr == '0) sr = 1'b0;  // single zero encoding
  end

  assign sum_o = {sr, mr};
endmodule

// File: rtl/acc_cpu_fsm.sv
module acc_cpu_fsm
  import acc_cpu_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [OP_W-1:0] op_i,
  input  logic            mem_ack_i,
  output state_e          state_o
);
  state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      S_FADR: st_d = S_FRD;
      S_FRD:  if (mem_ack_i) st_d = S_DEC;
      S_DEC:  st_d = S_EXE;
      S_EXE: begin
        if (op_i == OP_LOAD || op_i == OP_ADD) begin
          if (mem_ack_i) st_d = S_WB;
        end else if (op_i == OP_STORE) begin
          if (mem_ack_i) st_d = S_IRQ;
        end else begin
          st_d = S_IRQ;
        end
      end
      S_WB:   st_d = S_IRQ;
      S_IRQ:  st_d = S_FADR;
      default: st_d = S_FADR;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= S_FADR;
    else         st_q <= st_d;
  end

  assign state_o = st_q;
endmodule

// File: rtl/acc_cpu.sv
module acc_cpu
  import acc_cpu_pkg::*;
#(
  parameter int          ADDR_W   = 12,
  parameter int unsigned VEC_ADDR = 'hF00,
  parameter int unsigned RST_PC   = 0
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   irq_i,
  output logic                   mem_req_o,
  output logic                   mem_we_o,
  output logic [ADDR_W-1:0]      mem_addr_o,
  output logic [OP_W+ADDR_W-1:0] mem_wdata_o,
  input  logic [OP_W+ADDR_W-1:0] mem_rdata_i,
  input  logic                   mem_ack_i
);
  localparam int DATA_W = OP_W + ADDR_W;
  localparam logic [ADDR_W-1:0] VEC = ADDR_W'(VEC_ADDR);
  localparam logic [ADDR_W-1:0] RPC = ADDR_W'(RST_PC);

  state_e            st;
  logic [OP_W-1:0]   op_q;
  logic [ADDR_W-1:0] pc_q, mar_q, spc_q;
  logic [DATA_W-1:0] mbr_q, acc_q, sacc_q, sum;
  logic              ie_q, mem_op, take;

  acc_cpu_fsm u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .op_i      (op_q),
    .mem_ack_i (mem_ack_i),
    .state_o   (st)
  );

  acc_cpu_alu #(.DATA_W(DATA_W)) u_alu (
    .a_i   (acc_q),
    .b_i   (mbr_q),
    .sum_o (sum)
  );

  assign mem_op = (op_q == OP_LOAD) || (op_q == OP_ADD) || (op_q == OP_STORE);
  assign take   = (st == S_IRQ) && irq_i && ie_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q   <= RPC;
      mar_q  <= '0;
      mbr_q  <= '0;
      op_q   <= '0;
      acc_q  <= '0;
      ie_q   <= 1'b0;
      spc_q  <= RPC + 1'b1;
      sacc_q <= '0;
    end else begin
      unique case (st)
        S_FADR: mar_q <= pc_q;
        S_FRD:  if (mem_ack_i) mbr_q <= mem_rdata_i;
        S_DEC: begin
          op_q  <= mbr_q[DATA_W-1 -: OP_W];
          mar_q <= mbr_q[ADDR_W-1:0];
          mbr_q <= acc_q;
          pc_q  <= pc_q + 1'b1;
        end
        S_EXE: begin
          if (mem_ack_i && !(op_q == OP_STORE)) mbr_q <= mem_rdata_i;
          if (op_q == OP_RETI) begin
            pc_q  <= spc_q;
            acc_q <= sacc_q;
            ie_q  <= 1'b1;
          end
        end
        S_WB: acc_q <= (op_q == OP_LOAD) ? mbr_q : sum;
        S_IRQ: if (take) begin
          spc_q  <= pc_q;
          sacc_q <= acc_q;
          ie_q   <= 1'b0;
          pc_q   <= VEC;
        end
        default: ;
      endcase
    end
  end

  assign mem_req_o   = (st == S_FRD) || ((st == S_EXE) && mem_op);
  assign mem_we_o    = (st == S_EXE) && (op_q == OP_STORE);
  assign mem_addr_o  = mar_q;
  assign mem_wdata_o = mbr_q;

  // R2: program counter steps once per fetch
  p_pc_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == S_DEC) |=> (pc_q == $past(pc_q) + 1'b1));

  // R8: request held stable until acknowledged
  p_req_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o)
      && $stable(mem_we_o) && $stable(mem_wdata_o)));

  // R6: an add never leaves a negative zero
  p_zero_pos_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == S_WB && op_q == OP_ADD) |=> !(acc_q[DATA_W-1] && acc_q[DATA_W-2:0] == '0));

  // R9: taken request vectors and masks
  p_vector_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == S_IRQ && irq_i && ie_q) |=> (pc_q == VEC && !ie_q && st == S_FADR));

  // R10: masked request leaves the flow alone
  p_masked_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == S_IRQ && !ie_q) |=> (pc_q == $past(pc_q) && !ie_q));

  // R11: return re-enables
  p_return_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == S_EXE && op_q == OP_RETI) |=> ie_q);
endmodule

// File: tb/acc_cpu_tb_top.sv
module acc_cpu_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int TIMEOUT    = 20000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        irq = 1'b0;
  logic        req, we, ack = 1'b0;
  logic [11:0] addr;
  logic [15:0] wdata, rdata = '0;

  logic [15:0] mem [4096];
  logic [15:0] exp_mem [16];

  int n_chk = 0, n_bad = 0;
  bit done, seq_chk, pend, seen_first;
  int lat, seq_err, hs_err, vec_cnt, irq_off_cnt;
  logic [11:0] exp_fetch, stop_addr, irq_on_addr, irq_off_addr, first_addr, pa;
  logic        first_we, pw;
  logic [15:0] pwd;

  always #(CLK_PERIOD/2) clk = ~clk;

  acc_cpu dut_i (
    .clk_i(clk), .rst_ni(rst_n), .irq_i(irq),
    .mem_req_o(req), .mem_we_o(we), .mem_addr_o(addr),
    .mem_wdata_o(wdata), .mem_rdata_i(rdata), .mem_ack_i(ack)
  );

  function automatic logic [15:0] sm_add_ref(input logic [15:0] a, input logic [15:0] b);
    int va, vb, s, m;
    va = a[15] ? -int'(a[14:0]) : int'(a[14:0]);
    vb = b[15] ? -int'(b[14:0]) : int'(b[14:0]);
    s  = va + vb;
    m  = (s < 0 ? -s : s) % 32768;
    return {(s < 0) && (m != 0), 15'(m)};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, expv);
    end
  endtask

  // memory responder with random latency; also watches the port traffic
  initial begin
    forever begin
      @(negedge clk);
      if (!rst_n) begin
        ack = 1'b0; pend = 1'b0;
      end else if (ack) begin
        ack = 1'b0; pend = 1'b0;
      end else begin
        if (pend && (!req || addr != pa || we != pw || (we && wdata != pwd))) hs_err++;
        pend = 1'b0;
        if (req) begin
          if (!seen_first) begin
            seen_first = 1'b1; first_addr = addr; first_we = we;
          end
          if (lat == 0) begin
            ack = 1'b1;
            lat = $urandom_range(0, 2);
            if (we) mem[addr] = wdata;
            else begin
              rdata = mem[addr];
              if (addr < 12'h800 || addr >= 12'hF00) begin
                if (seq_chk && addr != exp_fetch) seq_err++;
                exp_fetch = addr + 1'b1;
                if (addr == 12'hF00) vec_cnt++;
                if (addr == irq_on_addr) irq = 1'b1;
                if (addr == irq_off_addr && vec_cnt >= irq_off_cnt) irq = 1'b0;
                if (addr == stop_addr) done = 1'b1;
              end
            end
          end else begin
            lat--; pend = 1'b1; pa = addr; pw = we; pwd = wdata;
          end
        end
      end
    end
  end

  task automatic clear_mem();
    for (int i = 0; i < 4096; i++) mem[i] = 16'h0000;
  endtask

  task automatic run(input logic [11:0] stop, input bit irq_init);
    int cyc;
    @(negedge clk);
    rst_n = 1'b0;
    done = 0; seen_first = 0; seq_err = 0; hs_err = 0; vec_cnt = 0;
    exp_fetch = '0; lat = 0; stop_addr = stop; irq = irq_init;
    repeat (3) begin
      @(negedge clk);
      chk(req == 1'b0, "R1 no request in reset", 32'(req), 0);
    end
    rst_n = 1'b1;
    cyc = 0;
    while (!done && cyc < TIMEOUT) begin
      @(negedge clk);
      cyc++;
    end
    chk(done, "watchdog expired", 32'(cyc), TIMEOUT);
    chk(hs_err == 0, "R8 request held until ack", 32'(hs_err), 0);
  endtask

  initial begin
    void'($urandom(32'd2024));
    irq_on_addr = 12'hFFF; irq_off_addr = 12'hFFF; irq_off_cnt = 0;

    // directed add and load corners
    clear_mem();
    mem[12'h000] = 16'h1800; mem[12'h001] = 16'h5801; mem[12'h002] = 16'h2802;
    mem[12'h003] = 16'h1803; mem[12'h004] = 16'h2804; mem[12'h005] = 16'h5805;
    mem[12'h006] = 16'h2806; mem[12'h007] = 16'h1807; mem[12'h008] = 16'h5808;
    mem[12'h009] = 16'h2809; mem[12'h00A] = 16'h180D; mem[12'h00B] = 16'h580A;
    mem[12'h00C] = 16'h280E; mem[12'h00D] = 16'h180A; mem[12'h00E] = 16'h580B;
    mem[12'h00F] = 16'h280C;
    mem[12'h800] = 16'h0005; mem[12'h801] = 16'h8005; mem[12'h803] = 16'h8000;
    mem[12'h805] = 16'h0000; mem[12'h807] = 16'h7FFF; mem[12'h808] = 16'h0001;
    mem[12'h80A] = 16'h8003; mem[12'h80B] = 16'h0007; mem[12'h80D] = 16'h0002;
    seq_chk = 1;
    run(12'h012, 1'b0);
    chk(first_addr == 12'h000 && !first_we, "R1 first access read at 0", {first_we, first_addr}, 0);
    chk(seq_err == 0, "R2 sequential fetch", 32'(seq_err), 0);
    chk(mem[12'h802] == 16'h0000, "R6 +5 plus -5", mem[12'h802], 16'h0000);
    chk(mem[12'h804] == 16'h8000, "R3 load of negative zero", mem[12'h804], 16'h8000);
    chk(mem[12'h806] == 16'h0000, "R6 -0 plus +0", mem[12'h806], 16'h0000);
    chk(mem[12'h809] == 16'h0000, "R5 magnitude wrap", mem[12'h809], 16'h0000);
    chk(mem[12'h80E] == 16'h8001, "R6 +2 plus -3", mem[12'h80E], 16'h8001);
    chk(mem[12'h80C] == 16'h0004, "R6 -3 plus +7", mem[12'h80C], 16'h0004);

    // random programs against an instruction-level model
    for (int run_i = 0; run_i < 5; run_i++) begin
      logic [15:0] acc, w;
      logic [3:0]  undef [12];
      undef = '{4'h0, 4'h3, 4'h4, 4'h6, 4'h7, 4'h8, 4'h9, 4'hA, 4'hB, 4'hC, 4'hD, 4'hE};
      clear_mem();
      for (int k = 0; k < 16; k++) begin
        case ($urandom_range(0, 5))
          0: mem[12'h800 + k] = 16'h8000;
          1: mem[12'h800 + k] = 16'h7FFF;
          2: mem[12'h800 + k] = {$urandom_range(0, 1) == 1, 15'($urandom_range(0, 15))};
          default: mem[12'h800 + k] = 16'($urandom);
        endcase
        exp_mem[k] = mem[12'h800 + k];
      end
      for (int i = 0; i < 48; i++) begin
        int r;
        logic [11:0] opa;
        r = $urandom_range(0, 9);
        opa = 12'h800 + 12'($urandom_range(0, 15));
        if (r < 3)      mem[i] = {4'h1, opa};
        else if (r < 5) mem[i] = {4'h2, opa};
        else if (r < 8) mem[i] = {4'h5, opa};
        else            mem[i] = {undef[$urandom_range(0, 11)], 12'($urandom)};
      end
      acc = '0;
      for (int i = 0; i < 48; i++) begin
        w = mem[i];
        case (w[15:12])
          4'h1: acc = exp_mem[w[3:0]];
          4'h2: exp_mem[w[3:0]] = acc;
          4'h5: acc = sm_add_ref(acc, exp_mem[w[3:0]]);
          default: ;
        endcase
      end
      run(12'd50, 1'b0);
      chk(seq_err == 0, "R2 sequential fetch", 32'(seq_err), 0);
      for (int k = 0; k < 16; k++)
        chk(mem[12'h800 + k] == exp_mem[k], "R4/R5/R7 data word vs model (R3 R4 R5 R7)",
            mem[12'h800 + k], exp_mem[k]);
    end
    seq_chk = 0;

    // request ignored while disabled after reset
    clear_mem();
    mem[12'h000] = 16'h1800; mem[12'h001] = 16'h2801; mem[12'h800] = 16'h1234;
    mem[12'hF00] = 16'h2802;
    run(12'h006, 1'b1);
    chk(vec_cnt == 0, "R10 no entry while disabled after reset", 32'(vec_cnt), 0);
    chk(mem[12'h802] == 16'h0000, "R10 handler store absent", mem[12'h802], 0);
    chk(mem[12'h801] == 16'h1234, "R3 load then store", mem[12'h801], 16'h1234);

    // single interrupt entry and return
    for (int t = 0; t < 2; t++) begin
      clear_mem();
      mem[12'h000] = 16'hF000; mem[12'h001] = 16'h1800; mem[12'h002] = 16'h2801;
      mem[12'h003] = 16'h2804;
      mem[12'hF00] = 16'h1802; mem[12'hF01] = 16'h5802; mem[12'hF02] = 16'h2803;
      mem[12'hF03] = 16'hF000;
      mem[12'h800] = 16'h0123; mem[12'h802] = 16'h8011;
      irq_on_addr = 12'h002;
      if (t == 0) begin irq_off_addr = 12'hF01; irq_off_cnt = 1; end
      else        begin irq_off_addr = 12'hF00; irq_off_cnt = 2; end
      run(12'h008, 1'b0);
      chk(vec_cnt == t + 1, t == 0 ? "R9 one handler entry" : "R10 pending request retaken after return",
          32'(vec_cnt), 32'(t + 1));
      chk(mem[12'h801] == 16'h0123, "R9 interrupted instruction completes", mem[12'h801], 16'h0123);
      chk(mem[12'h803] == 16'h8022, "R9 handler ran", mem[12'h803], 16'h8022);
      chk(mem[12'h804] == 16'h0123, "R11 accumulator restored on return", mem[12'h804], 16'h0123);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule